// File: doc/BRIEF.md
# Toothed-Wheel Angle Counter

This block turns the tooth pulses of a toothed-wheel sensor into a 24-bit angle count. Downstream compare and capture channels use this count as a time base. The block measures the number of clock cycles between successive teeth. For each new tooth interval it then releases a configured number of evenly paced ticks. The pacing is derived from the last measured tooth period by a fractional accumulator, so no divider is needed. Each tick raises the angle count by one.

When a tooth arrives before all ticks of the current interval have been released, the leftover ticks are released at one per clock before pacing resumes. When all ticks are out and no tooth has come, the count holds. A gap longer than a programmable multiple of the last period is taken as a missing tooth: one extra interval's worth of ticks is released and the learned period is kept. If the count holds longer than a programmable timeout, the block reports a stall and drops its synchronisation. After that, the next tooth only restarts period measurement.

The count never decreases and never moves by more than one per clock.

Top module: `tooth_angle_counter`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `angle_o` is 0 and `missing_o` and `stall_o` are 0.
- R2: A tooth is a rising edge of `tooth_i`; a level held high for several cycles is one tooth. The first tooth after reset or after a stall only starts measuring. Every later tooth closes the running interval and opens a new one. Over each interval the angle advances by exactly the `ticks_per_tooth_i` value sampled at the tooth that opened it.
- R3: `angle_o` changes by 0 or +1 (modulo 2^24) on every clock; it never goes backward.
- R4: A tooth that comes before all ticks of its interval are out causes the missing ticks to be issued at one per clock, ahead of the new interval's paced ticks; no tick is lost.
- R5: Once every tick of the interval has been issued and no tooth has come, `angle_o` holds.
- R6: When the gap closed by a tooth is greater than `gap_ratio_i` times the last learned period, `missing_o` pulses high for one clock and one extra `ticks_per_tooth_i` ticks are added. The learned period is not updated by that gap.
- R7: `stall_o` rises once the block has been synchronised and idle for `stall_limit_i` clocks. The tooth that ends a stall reports no missing tooth and adds no ticks. It starts a fresh measurement instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tooth_i | input | 1 | Synchronised tooth signal; each rising edge is one tooth |
| ticks_per_tooth_i | input | 8 | Ticks released per tooth interval |
| gap_ratio_i | input | 4 | Multiple of the last period beyond which a gap is a missing tooth |
| stall_limit_i | input | 16 | Idle clocks before a stall is reported |
| angle_o | output | 24 | Angle count for the time-base bus |
| missing_o | output | 1 | One-clock pulse on a detected missing tooth |
| stall_o | output | 1 | High while the count has been idle past the timeout |

## Verification
The hardest case to reach is a missing tooth that must leave the learned period intact. A second, shorter gap must still be judged against the old period. The bench therefore follows one long gap with a gap that is missing only if the period was kept. The early-tooth burst is reached by shortening the tooth spacing abruptly. Tick totals are compared only when the block reports a stall, so the expected counts do not depend on exactly where inside an interval each paced tick falls.

// File: rtl/tac_pkg.sv
package tac_pkg;
  typedef struct packed {
    logic open;  // tooth closes one interval and opens the next
    logic miss;  // closed gap judged as a missing tooth
  } tooth_ev_t;
endpackage

// File: rtl/tac_edge_det.sv
module tac_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tooth_i,
  output logic edge_o
);
  logic tooth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tooth_q <= 1'b0;
    else         tooth_q <= tooth_i;
  end

  assign edge_o = tooth_i & ~tooth_q;
endmodule

// File: rtl/tac_period_meter.sv
module tac_period_meter
  import tac_pkg::*;
#(
  parameter int unsigned PER_W   = 20,
  parameter int unsigned RATIO_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               edge_i,
  input  logic               stall_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output tooth_ev_t          ev_o,
  output logic               valid_o,
  output logic [PER_W-1:0]   pace_per_o
);
  localparam int unsigned PROD_W = PER_W + RATIO_W;

  logic [PER_W-1:0]  elapsed_q, period_q;
  logic              have_q, valid_q;
  logic [PROD_W-1:0] gap_limit;
  logic              gap_long;

  assign gap_limit  = PROD_W'(ratio_i) * PROD_W'(period_q);
  assign gap_long   = PROD_W'(elapsed_q) > gap_limit;

  assign ev_o.open  = edge_i & have_q & ~stall_i;
  assign ev_o.miss  = edge_i & have_q & ~stall_i & valid_q & gap_long;
  assign pace_per_o = ev_o.miss ? period_q : elapsed_q;
  assign valid_o    = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed_q <= '0;
      period_q  <= '0;
      have_q    <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      if (edge_i)              elapsed_q <= PER_W'(1);
      else if (~&elapsed_q)    elapsed_q <= elapsed_q + 1'b1;
      if (edge_i) begin
        have_q  <= 1'b1;
        valid_q <= ev_o.open;
        if (ev_o.open && !ev_o.miss) period_q <= elapsed_q;
      end
    end
  end

  AST_PERIOD_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o.miss |=> $stable(period_q)); // R6
endmodule

// File: rtl/tac_tick_gen.sv
module tac_tick_gen
  import tac_pkg::*;
#(
  parameter int unsigned TPT_W = 8,
  parameter int unsigned PER_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tooth_ev_t        ev_i,
  input  logic [TPT_W-1:0] tpt_i,
  input  logic [PER_W-1:0] pace_per_i,
  output logic             tick_o,
  output logic             idle_o
);
  localparam int unsigned ACC_W = PER_W + 1;
  localparam int unsigned OWE_W = TPT_W + 2;

  logic [TPT_W-1:0] tpt_q, left_q;
  logic [PER_W-1:0] per_q;
  logic [OWE_W-1:0] owed_q;
  logic [ACC_W-1:0] acc_q, acc_sum;
  logic             fire;

  assign acc_sum = acc_q + ACC_W'(tpt_q);
  assign fire    = acc_sum >= ACC_W'(per_q);
  assign tick_o  = ~ev_i.open & ((owed_q != '0) | ((left_q != '0) & fire));
  assign idle_o  = (owed_q == '0) & (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpt_q  <= '0;
      left_q <= '0;
      per_q  <= '0;
      owed_q <= '0;
      acc_q  <= '0;
    end else if (ev_i.open) begin
      owed_q <= owed_q + OWE_W'(left_q) + (ev_i.miss ? OWE_W'(tpt_i) : '0);
      left_q <= tpt_i;
      tpt_q  <= tpt_i;
      per_q  <= pace_per_i;
      acc_q  <= '0;
    end else if (owed_q != '0) begin
      owed_q <= owed_q - 1'b1;  // catch-up burst, pacing paused
    end else if (left_q != '0) begin
      if (fire) begin
        acc_q  <= acc_sum - ACC_W'(per_q);
        left_q <= left_q - 1'b1;
      end else begin
        acc_q  <= acc_sum;
      end
    end
  end

  AST_OWED_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owed_q != '0 && !ev_i.open) |=> owed_q == $past(owed_q) - 1'b1); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !ev_i.open) |=> idle_o); // R5
endmodule

// File: rtl/tooth_angle_counter.sv
module tooth_angle_counter
  import tac_pkg::*;
#(
  parameter int unsigned ANGLE_W = 24,
  parameter int unsigned TPT_W   = 8,
  parameter int unsigned PER_W   = 20,
  parameter int unsigned RATIO_W = 4,
  parameter int unsigned STALL_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tooth_i,
  input  logic [TPT_W-1:0]   ticks_per_tooth_i,
  input  logic [RATIO_W-1:0] gap_ratio_i,
  input  logic [STALL_W-1:0] stall_limit_i,
  output logic [ANGLE_W-1:0] angle_o,
  output logic               missing_o,
  output logic               stall_o
);
  logic             tooth_edge, valid, tick, idle;
  tooth_ev_t        ev;
  logic [PER_W-1:0] pace_per;
  logic [ANGLE_W-1:0] angle_q;
  logic [STALL_W-1:0] stall_cnt_q;
  logic               missing_q;

  tac_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tooth_i (tooth_i),
    .edge_o  (tooth_edge)
  );

  tac_period_meter #(.PER_W(PER_W), .RATIO_W(RATIO_W)) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_i     (tooth_edge),
    .stall_i    (stall_o),
    .ratio_i    (gap_ratio_i),
    .ev_o       (ev),
    .valid_o    (valid),
    .pace_per_o (pace_per)
  );

  tac_tick_gen #(.TPT_W(TPT_W), .PER_W(PER_W)) u_ticks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .tpt_i      (ticks_per_tooth_i),
    .pace_per_i (pace_per),
    .tick_o     (tick),
    .idle_o     (idle)
  );

  assign stall_o   = stall_cnt_q >= stall_limit_i;
  assign angle_o   = angle_q;
  assign missing_o = missing_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      angle_q     <= '0;
      stall_cnt_q <= '0;
      missing_q   <= 1'b0;
    end else begin
      if (tick) angle_q <= angle_q + 1'b1;
      if (tooth_edge)                          stall_cnt_q <= '0;
      else if (valid && idle && ~&stall_cnt_q) stall_cnt_q <= stall_cnt_q + 1'b1;
      missing_q <= ev.miss;
    end
  end

  AST_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ANGLE_W'(angle_o - $past(angle_o)) <= ANGLE_W'(1)); // R3
  AST_STALL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(angle_o)); // R5
  AST_RESYNC_NO_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tooth_edge && stall_o) |=> !missing_o); // R7
  AST_MISS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    missing_o |=> !missing_o); // R6
endmodule

// File: tb/tooth_angle_counter_bench.sv
module tooth_angle_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tooth = 1'b0;
  logic [7:0]  tpt = 8'd8;
  logic [3:0]  ratio = 4'd2;
  logic [15:0] stall_lim = 16'd200;
  logic [23:0] angle;
  logic        missing, stall;

  typedef struct {
    int    angle;
    int    misses;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0, n_bad = 0, miss_cnt = 0, exp_angle = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  tooth_angle_counter u_tooth_angle_counter (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .tooth_i           (tooth),
    .ticks_per_tooth_i (tpt),
    .gap_ratio_i       (ratio),
    .stall_limit_i     (stall_lim),
    .angle_o           (angle),
    .missing_o         (missing),
    .stall_o           (stall)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // rising edge spaced `per` clocks from the next, held high for `hold`
  task automatic tooth_at(input int per, input int hold = 2);
    @(negedge clk) tooth = 1'b1;
    repeat (hold) @(negedge clk);
    tooth = 1'b0;
    repeat (per - hold - 1) @(negedge clk);
  endtask

  task automatic expect_phase(input int add, input int misses, input string req);
    exp_t e;
    exp_angle += add;
    e.angle = exp_angle; e.misses = misses; e.req = req;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) if (rst_n && missing) miss_cnt++;

  // monitor: each phase ends in a stall, where totals are compared
  initial begin
    forever begin
      @(posedge stall);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected stall", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(angle) == e.angle, e.req, int'(angle), e.angle);
        check(miss_cnt == e.misses, {e.req, " missing count R6"}, miss_cnt, e.misses);
        miss_cnt = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(angle == 0, "R1 angle in reset", int'(angle), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(angle == 0, "R1 angle after reset", int'(angle), 0);
    check(!missing && !stall, "R1 flags after reset", int'({missing, stall}), 0);

    // R2: steady train, long held level counts once
    expect_phase(8 * 5, 0, "R2 steady interval total");
    tpt = 8;
    for (int i = 0; i < 3; i++) tooth_at(40, 10);
    check(!stall, "R5 no stall while running", int'(stall), 0);
    for (int i = 0; i < 3; i++) tooth_at(40, 10);
    repeat (320) @(negedge clk);

    // R4: teeth abruptly earlier, leftover ticks burst
    expect_phase(8 * 5, 0, "R4 early tooth total");
    for (int i = 0; i < 3; i++) tooth_at(40);
    for (int i = 0; i < 3; i++) tooth_at(15);
    repeat (320) @(negedge clk);

    // R5: late teeth below the missing threshold, count holds then resumes
    expect_phase(6 * 4, 0, "R5 late tooth total");
    tpt = 6;
    tooth_at(30); tooth_at(30); tooth_at(30); tooth_at(50); tooth_at(50);
    repeat (320) @(negedge clk);

    // R6: gap 120 > 2*40 missing; then 90 > 2*40 only if period 40 kept
    expect_phase(8 * 5 + 8 * 2, 2, "R6 missing tooth total");
    tpt = 8;
    tooth_at(40); tooth_at(40); tooth_at(120); tooth_at(90); tooth_at(40); tooth_at(40);
    repeat (320) @(negedge clk);

    // R2: fractional spacing and tick count latched per opening tooth
    expect_phase(7 + 7 + 3 + 3, 0, "R2 ratio change total");
    tpt = 7;
    tooth_at(37); tooth_at(37); tooth_at(37);
    tpt = 3;
    tooth_at(37); tooth_at(37);
    repeat (320) @(negedge clk);
    check(exp_q.size() == 0, "R7 all phases reached stall", exp_q.size(), 0);

    // R7: tooth ending a stall adds nothing and reports no missing tooth
    miss_cnt = 0;
    tooth_at(100);
    check(int'(angle) == exp_angle, "R7 resync tooth adds no ticks", int'(angle), exp_angle);
    check(miss_cnt == 0, "R7 resync tooth not missing", miss_cnt, 0);
    check(!stall, "R7 stall cleared by tooth", int'(stall), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule